// File: doc/BRIEF.md
# RC Oscillator Trim Calibration Engine

This block tunes an on-chip RC oscillator by searching for the trim setting whose frequency matches a reference. It keeps a signed trim value, turns it into a 28-bit code made of seven 4-bit digits and drives that code to the oscillator. For each candidate it runs one measurement on an external counter block. The counter is clocked by the RC clock and gated by a reference window. The engine compares the count with a fixed load value and narrows the search.

After a fixed number of measurements the engine writes the chosen code with its enable bit set and asserts a hold signal so the analog side keeps the code. During the search the enable bit stays low. The block runs once per start pulse and reports `busy_o` while it works and `done_o` for one cycle when it finishes.

Top module: `rc_trim_cal`

## Requirements
- R1: After reset `busy_o`, `done_o`, `trim_en_o`, `trim_hold_o`, `cnt_load_we_o` and `cnt_start_o` are low and `cnt_rst_n_o` is high.
- R2: A `start_i` pulse while idle starts a run, so `busy_o` is high in the following cycle. A `start_i` pulse while busy has no effect on the run, its measurement count or its result.
- R3: Each measurement drives `cnt_rst_n_o` low for one cycle. The next cycle strobes `cnt_load_we_o` with `cnt_load_o` = 2048, and the cycle after that pulses `cnt_start_o`. The engine then waits for `meas_done_i` to be seen low before it accepts it high, so a done flag left over from the last measurement is never taken.
- R4: The trim code encodes a signed value v in -56..49 as seven 4-bit digits, with digit 0 in bits [3:0]. Let b = floor(v/7) and r = v - 7b. Digit i holds b+1 when i < r and b otherwise, taken modulo 16.
- R5: The first measurement of every run uses v = -4, with a step-size register of 53.
- R6: The measured difference is 2048 minus `meas_count_i`. If the difference is above +12, v drops by size/2. If it is below -12, v rises by size/2. Otherwise v is unchanged. After each measurement, size becomes (size+1)>>1.
- R7: Each run performs exactly 8 measurements.
- R8: When the eighth measurement finishes, `trim_code_o` holds the code of the final v, and `trim_en_o` and `trim_hold_o` are high. `done_o` is high for exactly one cycle and `busy_o` is low in that same cycle. `trim_en_o` is never high while `busy_o` is high.
- R9: When the oscillator's count falls monotonically as v rises and a matching code exists, the final code gives a difference within ±12.
- R10: Starting a run clears `trim_en_o` and `trim_hold_o`, and the trim code stays stable while a measurement is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a calibration run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the final code is latched |
| trim_code_o | output | 28 | Seven-digit trim code to the oscillator |
| trim_en_o | output | 1 | Trim code valid and applied |
| trim_hold_o | output | 1 | Retain the trim code |
| cnt_rst_n_o | output | 1 | Active-low reset to the measurement counter |
| cnt_load_we_o | output | 1 | Load strobe for the counter |
| cnt_load_o | output | 16 | Counter load value |
| cnt_start_o | output | 1 | Start one measurement window |
| meas_done_i | input | 1 | Measurement finished |
| meas_count_i | input | 16 | Counter value at the end of the window |

## Verification
The measurement model in the bench keeps `meas_done_i` high for two cycles after each start. An engine that accepted the stale done flag would compute its step from the previous count, and the next code it drove would not match. Targets that need negative trim values check the floor-based digit split, since a truncating split would give codes one step off near zero. A target beyond the top of the range drives the search to its upper limit and checks the rounding-up step sizes, which a truncating size update would leave short of the limit. A second start pulse in the middle of a run checks that the engine ignores it; a design that restarted would perform more than eight measurements.

// File: rtl/rc_trim_cal.sv
module rc_trim_cal #(
  parameter int CNT_W    = 16,
  parameter int LOAD_VAL = 2048,
  parameter int TOL      = 12,
  parameter int STEPS    = 8,
  parameter int TRIM_MIN = -56,
  parameter int TRIM_MAX = 49,
  parameter int DIGITS   = 7,
  parameter int DIG_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [DIGITS*DIG_W-1:0]   trim_code_o,
  output logic                      trim_en_o,
  output logic                      trim_hold_o,
  output logic                      cnt_rst_n_o,
  output logic                      cnt_load_we_o,
  output logic [CNT_W-1:0]          cnt_load_o,
  output logic                      cnt_start_o,
  input  logic                      meas_done_i,
  input  logic [CNT_W-1:0]          meas_count_i
);
  localparam int SPAN    = TRIM_MAX - TRIM_MIN + 1;
  localparam int UW      = $clog2(SPAN);
  localparam int U0      = TRIM_MAX - SPAN / 2 - TRIM_MIN;
  localparam int DIG_OFS = (-TRIM_MIN) / DIGITS;
  localparam int SW      = $clog2(SPAN / 2 + 1) + 1;
  localparam int IW      = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0]        LOADV = CNT_W'(LOAD_VAL);
  localparam logic signed [CNT_W:0]   TOLP  = (CNT_W+1)'(TOL);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_LOAD, S_GO, S_WLO, S_WHI} st_t;

  st_t               st_q;
  logic [UW-1:0]     u_q;
  logic [SW-1:0]     sz_q;
  logic [IW-1:0]     it_q;
  logic [UW-1:0]     step, q, m;
  logic signed [CNT_W:0] diff;

  assign busy_o        = (st_q != S_IDLE);
  assign cnt_rst_n_o   = (st_q != S_RST);
  assign cnt_load_we_o = (st_q == S_LOAD);
  assign cnt_start_o   = (st_q == S_GO);
  assign cnt_load_o    = LOADV;

  assign diff = $signed({1'b0, LOADV}) - $signed({1'b0, meas_count_i});
  assign step = UW'(sz_q >> 1);

  // u_q is the trim value offset so that the lowest value maps to zero
  assign q = u_q / UW'(DIGITS);
  assign m = u_q % UW'(DIGITS);

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign trim_code_o[i*DIG_W +: DIG_W] =
      DIG_W'(q + UW'(DIG_OFS) + UW'(UW'(i) < m));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      u_q         <= UW'(U0);
      sz_q        <= SW'(SPAN / 2);
      it_q        <= '0;
      trim_en_o   <= 1'b0;
      trim_hold_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          u_q         <= UW'(U0);
          sz_q        <= SW'(SPAN / 2);
          it_q        <= '0;
          trim_en_o   <= 1'b0;
          trim_hold_o <= 1'b0;
          st_q        <= S_RST;
        end
        S_RST:  st_q <= S_LOAD;
        S_LOAD: st_q <= S_GO;
        S_GO:   st_q <= S_WLO;
        S_WLO:  if (!meas_done_i) st_q <= S_WHI;
        S_WHI:  if (meas_done_i) begin
          if (diff > TOLP)       u_q <= u_q - step;
          else if (diff < -TOLP) u_q <= u_q + step;
          sz_q <= SW'((sz_q + SW'(1)) >> 1);
          it_q <= it_q + IW'(1);
          if (it_q == IW'(STEPS - 1)) begin
            trim_en_o   <= 1'b1;
            trim_hold_o <= 1'b1;
            done_o      <= 1'b1;
            st_q        <= S_IDLE;
          end else begin
            st_q <= S_RST;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R3
  load_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load_we_o |-> $past(!cnt_rst_n_o));
  // R3
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_start_o |-> $past(cnt_load_we_o));
  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!cnt_rst_n_o, cnt_load_we_o, cnt_start_o}));
  // R8
  en_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !trim_en_o);
  // R8
  done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (trim_en_o && trim_hold_o && !busy_o));
  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && st_q != S_WHI) |=> busy_o);
  // R10
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WLO || st_q == S_WHI) |-> $stable(trim_code_o));
  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_q <= UW'(SPAN - 1));
  // R7
  iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    it_q <= IW'(STEPS));
endmodule

// File: tb/rc_trim_cal_tb_top.sv
`timescale 1ns/1ps
module rc_trim_cal_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, trim_en_o, trim_hold_o;
  logic cnt_rst_n_o, cnt_load_we_o, cnt_start_o;
  logic [27:0] trim_code_o;
  logic [15:0] cnt_load_o;
  logic meas_done_i = 1'b1;
  logic [15:0] meas_count_i = '0;

  always #5 clk = ~clk;

  rc_trim_cal dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .trim_code_o(trim_code_o), .trim_en_o(trim_en_o), .trim_hold_o(trim_hold_o),
    .cnt_rst_n_o(cnt_rst_n_o), .cnt_load_we_o(cnt_load_we_o), .cnt_load_o(cnt_load_o),
    .cnt_start_o(cnt_start_o), .meas_done_i(meas_done_i), .meas_count_i(meas_count_i));

  int n_chk = 0, n_err = 0;
  int slope = 5, tgt = 0;
  int exp_v, exp_sz, n_meas;
  int m_dly = 0, m_run = 0;
  bit prev_rst_low = 0, prev_load = 0, finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] enc(int v);
    int b, r;
    logic [27:0] c;
    b = (v >= 0) ? v / 7 : -((-v + 6) / 7);
    r = v - 7 * b;
    c = '0;
    for (int i = 0; i < 7; i++) c[i*4 +: 4] = 4'((i < r) ? b + 1 : b);
    return c;
  endfunction

  function automatic int dec(logic [27:0] c);
    int s = 0;
    for (int i = 0; i < 7; i++) s += (c[i*4 +: 4] >= 8) ? int'(c[i*4 +: 4]) - 16 : int'(c[i*4 +: 4]);
    return s;
  endfunction

  // oscillator / counter model and per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) chk(!trim_en_o, "R8", "enable high while busy", trim_en_o, 0);
      if (cnt_load_we_o) begin
        chk(prev_rst_low, "R3", "load without preceding counter reset", 0, 1);
        chk(cnt_load_o == 16'd2048, "R3", "load value", cnt_load_o, 2048);
      end
      if (cnt_start_o) begin
        chk(prev_load, "R3", "start without preceding load", 0, 1);
        chk(trim_code_o == enc(exp_v), "R4", "code at measurement", trim_code_o, enc(exp_v));
        n_meas++;
      end
      if (m_dly > 0) begin
        m_dly--;
        if (m_dly == 0) begin meas_done_i = 1'b0; m_run = 5; end
      end else if (m_run > 0) begin
        m_run--;
        if (m_run == 0) begin
          int cnt, d;
          cnt = 2048 - slope * (dec(trim_code_o) - tgt);
          meas_count_i = 16'(cnt);
          meas_done_i = 1'b1;
          d = 2048 - cnt;
          if (d > 12) exp_v -= exp_sz / 2;
          else if (d < -12) exp_v += exp_sz / 2;
          exp_sz = (exp_sz + 1) >> 1;
        end
      end
      if (cnt_start_o) m_dly = 2;
      prev_rst_low = !cnt_rst_n_o;
      prev_load = cnt_load_we_o;
    end
  end

  task automatic run_case(int s, int t, bit conv, bit poke);
    logic [27:0] fc;
    int w;
    slope = s; tgt = t;
    exp_v = -4; exp_sz = 53; n_meas = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R2", "busy after start", busy_o, 1);
    chk(!trim_en_o && !trim_hold_o, "R10", "en/hold cleared on start", {trim_en_o, trim_hold_o}, 0);
    chk(trim_code_o == enc(-4), "R5", "initial code", trim_code_o, enc(-4));
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 3000) begin @(negedge clk); w++; end
    chk(done_o, "R8", "done seen", done_o, 1);
    chk(trim_code_o == enc(exp_v), "R6", "final code", trim_code_o, enc(exp_v));
    chk(trim_en_o && trim_hold_o, "R8", "en/hold at end", {trim_en_o, trim_hold_o}, 3);
    chk(!busy_o, "R8", "busy low at done", busy_o, 0);
    chk(n_meas == 8, "R7", "measurement count", n_meas, 8);
    if (poke) chk(n_meas == 8, "R2", "start while busy ignored", n_meas, 8);
    if (conv) begin
      int d;
      d = slope * (dec(trim_code_o) - tgt);
      chk(d <= 12 && d >= -12, "R9", "final difference", d, 0);
    end
    fc = trim_code_o;
    @(negedge clk);
    chk(!done_o, "R8", "done one cycle", done_o, 0);
    chk(trim_code_o == fc && trim_en_o && trim_hold_o, "R8", "final code held", trim_code_o, fc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    chk(!trim_en_o && !trim_hold_o, "R1", "en/hold in reset", {trim_en_o, trim_hold_o}, 0);
    chk(cnt_rst_n_o && !cnt_load_we_o && !cnt_start_o, "R1", "counter controls in reset",
        {cnt_rst_n_o, cnt_load_we_o, cnt_start_o}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o, "R1", "idle after reset", busy_o, 0);
    run_case(5, -4, 1, 0);
    run_case(3, 30, 1, 1);
    run_case(4, -50, 1, 0);
    run_case(2, -56, 1, 0);
    run_case(5, 60, 0, 0);
    chk(dec(trim_code_o) == 48, "R6", "upper search limit", dec(trim_code_o), 48);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule